// File: doc/BRIEF.md
# Fixed-Priority Interrupt Arbiter

This block chooses which of five interrupt sources a small processor core services next. One source cannot be masked and is meant for emergencies such as a power failure. Three sources can each be masked on their own. A fifth, general-purpose request relies on the core to fetch its vector from outside, so it gets an acknowledge strobe. A global enable gates every source except the non-maskable one. Servicing any interrupt drops that enable until software sets it again.

Each cycle the block presents one candidate to the core: a registered request flag, the winning source index and a fixed 16-bit vector address. When the core accepts, the block records the source as in service and clears any stored request for that source. Same-priority and lower-priority sources then stay blocked until the core signals a return from service. A higher-priority source can still preempt the one in service. The block has no vector fetch and no stack handling.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `take_o` and `ack_gen_o` are low, the global enable is off, nothing is in service and no stored edge is held.
- R2: Source indices are 0 (non-maskable), 1 (edge source), 2 (level A), 3 (level B), 4 (general). Among eligible sources the lowest index wins. `vec_o` is 0x0024, 0x003C, 0x0034, 0x002C or 0x0000 for indices 0 to 4.
- R3: The non-maskable source is pending only after a low-to-high transition, and only while its input stays high. Dropping the input withdraws it. The global enable and the masks do not affect it.
- R4: A rising edge on `irq_edge_i` is stored and kept after the input falls. The store is cleared by acceptance of index 1 or by `edge_clr_i`. Mask bit 0 blocks presentation of the stored edge but does not stop it from being stored.
- R5: Level sources A and B are pending only while their inputs are high. Mask bits 1 and 2 block them (1 = blocked).
- R6: Indices 1 to 4 are presented only while the global enable is on. `en_set_i` turns the enable on and `en_clr_i` turns it off. An acceptance turns it off and wins over `en_set_i` in the same cycle.
- R7: `take_o`, `win_idx_o` and `vec_o` are registered. They reflect state and inputs at the previous clock edge. Acceptance happens when `accept_i` is high while `take_o` is high. In that case `take_o` is low in the next cycle.
- R8: `ack_gen_o` pulses for exactly one cycle, one cycle after the acceptance of index 4, and at no other time.
- R9: An accepted source is marked in service. While a source is in service, no source of equal or lower priority is presented. `ret_i` ends service of the highest-priority source in service.
- R10: `accept_i` while `take_o` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_nmi_i | input | 1 | Non-maskable source, edge plus level qualified |
| irq_edge_i | input | 1 | Edge-stored maskable source |
| irq_lva_i | input | 1 | Level maskable source A |
| irq_lvb_i | input | 1 | Level maskable source B |
| irq_gen_i | input | 1 | General-purpose level request |
| mask_i | input | 3 | Per-source block bits: [0] edge, [1] level A, [2] level B |
| en_set_i | input | 1 | Turn the global enable on |
| en_clr_i | input | 1 | Turn the global enable off |
| edge_clr_i | input | 1 | Discard a stored edge request |
| accept_i | input | 1 | Core takes the presented interrupt |
| ret_i | input | 1 | Core finished the current service routine |
| take_o | output | 1 | Interrupt presented to the core |
| win_idx_o | output | 3 | Index of the presented source |
| vec_o | output | 16 | Fixed vector address of the presented source |
| ack_gen_o | output | 1 | Acknowledge strobe for the general request |

## Verification
The assertions assume that every request input and core control is synchronous to `clk`. They also assume the core raises `accept_i` only as a one-cycle decision taken from the `take_o` value it sees. The stimulus changes every input only a couple of nanoseconds after a rising edge, so no input ever moves near the sampling edge. Random acceptance is biased towards cycles where `take_o` is high, and stray acceptances while it is low are kept rare. This keeps the handshake realistic while still covering the ignored case.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NSRC  = 5;
  localparam int IDX_W = $clog2(NSRC);
  localparam int VEC_W = 16;
  localparam int NMSK  = 3;

  localparam logic [IDX_W-1:0] IDX_NMI  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_EDGE = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_LVA  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_LVB  = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_GEN  = IDX_W'(4);

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_NMI:  vec_of = VEC_W'(16'h0024);
      IDX_EDGE: vec_of = VEC_W'(16'h003C);
      IDX_LVA:  vec_of = VEC_W'(16'h0034);
      IDX_LVB:  vec_of = VEC_W'(16'h002C);
      default:  vec_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/irq_pri_pick.sv
module irq_pri_pick #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_trap_qual.sv
module irq_trap_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic svc_i,
  output logic pend_o
);
  logic prev_q, arm_q, arm_d;

  always_comb begin
    arm_d = arm_q;
    if (svc_i || !lvl_i) arm_d = 1'b0;
    if (lvl_i && !prev_q) arm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      arm_q  <= arm_d;
    end
  end

  assign pend_o = arm_q & lvl_i;
endmodule

// File: rtl/irq_edge_hold.sv
module irq_edge_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  input  logic svc_i,
  input  logic clr_i,
  output logic held_o
);
  logic prev_q, held_q, held_d;

  always_comb begin
    held_d = held_q;
    if (svc_i || clr_i) held_d = 1'b0;
    if (sig_i && !prev_q) held_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      prev_q <= sig_i;
      held_q <= held_d;
    end
  end

  assign held_o = held_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_nmi_i,
  input  logic             irq_edge_i,
  input  logic             irq_lva_i,
  input  logic             irq_lvb_i,
  input  logic             irq_gen_i,
  input  logic [NMSK-1:0]  mask_i,
  input  logic             en_set_i,
  input  logic             en_clr_i,
  input  logic             edge_clr_i,
  input  logic             accept_i,
  input  logic             ret_i,
  output logic             take_o,
  output logic [IDX_W-1:0] win_idx_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             ack_gen_o
);
  logic             take_q, take_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             ack_q, ack_d;
  logic             gie_q, gie_d;
  logic [NSRC-1:0]  isr_q, isr_d;

  logic             svc;
  logic [NSRC-1:0]  svc_oh;
  logic             nmi_pend, edge_held;
  logic [NSRC-1:0]  pend, blocked, elig;
  logic             cand_any;
  logic [IDX_W-1:0] cand_idx;
  logic             isr_any;
  logic [IDX_W-1:0] isr_top;
  logic [NSRC-1:0]  ret_oh;

  assign svc = accept_i & take_q;

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign svc_oh[s]  = svc && (idx_q == IDX_W'(s));
      assign blocked[s] = |isr_q[s:0];
      assign ret_oh[s]  = ret_i && isr_any && (isr_top == IDX_W'(s));
    end
  endgenerate

  irq_trap_qual u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (irq_nmi_i),
    .svc_i  (svc_oh[IDX_NMI]),
    .pend_o (nmi_pend)
  );

  irq_edge_hold u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (irq_edge_i),
    .svc_i  (svc_oh[IDX_EDGE]),
    .clr_i  (edge_clr_i),
    .held_o (edge_held)
  );

  assign pend[IDX_NMI]  = nmi_pend;
  assign pend[IDX_EDGE] = gie_q & edge_held  & ~mask_i[0];
  assign pend[IDX_LVA]  = gie_q & irq_lva_i  & ~mask_i[1];
  assign pend[IDX_LVB]  = gie_q & irq_lvb_i  & ~mask_i[2];
  assign pend[IDX_GEN]  = gie_q & irq_gen_i;
  assign elig = pend & ~blocked;

  irq_pri_pick #(.N(NSRC), .IW(IDX_W)) u_pick (
    .req (elig),
    .any (cand_any),
    .idx (cand_idx)
  );

  irq_pri_pick #(.N(NSRC), .IW(IDX_W)) u_isr_top (
    .req (isr_q),
    .any (isr_any),
    .idx (isr_top)
  );

  always_comb begin
    take_d = cand_any & ~svc;
    idx_d  = idx_q;
    vec_d  = vec_q;
    if (take_d) begin
      idx_d = cand_idx;
      vec_d = vec_of(cand_idx);
    end
    ack_d = svc_oh[IDX_GEN];

    gie_d = gie_q;
    if (en_clr_i) gie_d = 1'b0;
    if (en_set_i) gie_d = 1'b1;
    if (svc)      gie_d = 1'b0;

    isr_d = (isr_q & ~ret_oh) | svc_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      idx_q  <= '0;
      vec_q  <= '0;
      ack_q  <= 1'b0;
      gie_q  <= 1'b0;
      isr_q  <= '0;
    end else begin
      take_q <= take_d;
      idx_q  <= idx_d;
      vec_q  <= vec_d;
      ack_q  <= ack_d;
      gie_q  <= gie_d;
      isr_q  <= isr_d;
    end
  end

  assign take_o    = take_q;
  assign win_idx_o = idx_q;
  assign vec_o     = vec_q;
  assign ack_gen_o = ack_q;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
  import irq_arb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             accept_i,
  input logic             take_o,
  input logic [IDX_W-1:0] win_idx_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             ack_gen_o,
  input logic             gie_q
);
  AST_IDX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (win_idx_o <= IDX_GEN)); // R2

  AST_VEC_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && win_idx_o == IDX_NMI) |-> (vec_o == 16'h0024)); // R2

  AST_MASKABLE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && win_idx_o != IDX_NMI) |-> $past(gie_q)); // R6

  AST_ACCEPT_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && take_o) |=> !gie_q); // R6

  AST_TAKE_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && take_o) |=> !take_o); // R7

  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_gen_o |-> $past(accept_i && take_o && win_idx_o == IDX_GEN)); // R8

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_gen_o |=> !ack_gen_o); // R8
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept_i  (accept_i),
  .take_o    (take_o),
  .win_idx_o (win_idx_o),
  .vec_o     (vec_o),
  .ack_gen_o (ack_gen_o),
  .gie_q     (gie_q)
);

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic nmi, edg, lva, lvb, gen;
  logic [2:0] mask;
  logic en_set, en_clr, eclr, acc, ret;
  logic take;
  logic [2:0] idx;
  logic [15:0] vec;
  logic ack;

  int total = 0;
  int bad = 0;

  // reference state
  logic m_take, m_ack, m_gie, m_pn, m_arm, m_pe, m_held;
  logic [2:0] m_idx;
  logic [4:0] m_isr;

  always #4 clk = ~clk;

  irq_arbiter u_irq_arbiter (
    .clk(clk), .rst_n(rst_n),
    .irq_nmi_i(nmi), .irq_edge_i(edg), .irq_lva_i(lva), .irq_lvb_i(lvb), .irq_gen_i(gen),
    .mask_i(mask), .en_set_i(en_set), .en_clr_i(en_clr), .edge_clr_i(eclr),
    .accept_i(acc), .ret_i(ret),
    .take_o(take), .win_idx_o(idx), .vec_o(vec), .ack_gen_o(ack)
  );

  function automatic logic [15:0] exp_vec(input logic [2:0] i);
    case (i)
      3'd0: exp_vec = 16'h0024;
      3'd1: exp_vec = 16'h003C;
      3'd2: exp_vec = 16'h0034;
      3'd3: exp_vec = 16'h002C;
      default: exp_vec = 16'h0000;
    endcase
  endfunction

  task automatic model_edge();
    logic svc;
    logic [4:0] p;
    logic any;
    logic [2:0] w;
    svc = acc && m_take;
    p[0] = m_arm && nmi;
    p[1] = m_gie && m_held && !mask[0];
    p[2] = m_gie && lva && !mask[1];
    p[3] = m_gie && lvb && !mask[2];
    p[4] = m_gie && gen;
    any = 1'b0;
    w = 3'd0;
    for (int s = 0; s < 5; s++) begin
      logic blk;
      blk = 1'b0;
      for (int k = 0; k <= s; k++) if (m_isr[k]) blk = 1'b1;
      if (!any && p[s] && !blk) begin any = 1'b1; w = 3'(s); end
    end
    m_ack = svc && (m_idx == 3'd4);
    if (ret) begin
      for (int k = 0; k < 5; k++) if (m_isr[k]) begin m_isr[k] = 1'b0; break; end
    end
    if (svc) m_isr[m_idx] = 1'b1;
    if ((svc && m_idx == 3'd0) || !nmi) m_arm = 1'b0;
    if (nmi && !m_pn) m_arm = 1'b1;
    m_pn = nmi;
    if ((svc && m_idx == 3'd1) || eclr) m_held = 1'b0;
    if (edg && !m_pe) m_held = 1'b1;
    m_pe = edg;
    if (en_clr) m_gie = 1'b0;
    if (en_set) m_gie = 1'b1;
    if (svc) m_gie = 1'b0;
    m_take = any && !svc;
    if (m_take) m_idx = w;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv, input string what);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    #2;
    chk(tag, 32'(take), 32'(m_take), "take");
    if (m_take) begin
      chk(tag, 32'(idx), 32'(m_idx), "idx");
      chk(tag, 32'(vec), 32'(exp_vec(m_idx)), "vec");
    end
    chk(tag, 32'(ack), 32'(m_ack), "ack");
    en_set = 0; en_clr = 0; eclr = 0; acc = 0; ret = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #1600000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    rst_n = 0;
    {nmi, edg, lva, lvb, gen} = '0;
    mask = '0; en_set = 0; en_clr = 0; eclr = 0; acc = 0; ret = 0;
    m_take = 0; m_ack = 0; m_gie = 0; m_pn = 0; m_arm = 0; m_pe = 0; m_held = 0;
    m_idx = 0; m_isr = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", 32'(take), 0, "take in reset");
    chk("R1", 32'(ack), 0, "ack in reset");
    rst_n = 1;
    idle(2, "R1");

    // R6: maskables ignored while enable off
    lvb = 1; idle(3, "R6");
    chk("R6", 32'(take), 0, "no take with enable off");
    en_set = 1; idle(2, "R6");
    chk("R5", 32'(idx), 3, "level B presented");
    // R2: higher level wins
    lva = 1; idle(1, "R2");
    chk("R2", 32'(vec), 32'h0034, "level A vector");
    // R10: accept while nothing presented is covered later; accept now
    acc = 1; idle(1, "R7");
    chk("R7", 32'(take), 0, "take drops after accept");
    idle(2, "R6");
    chk("R6", 32'(take), 0, "enable cleared by accept");
    // R9: level A in service; re-enable, B blocked, A blocked
    en_set = 1; idle(3, "R9");
    chk("R9", 32'(take), 0, "lower blocked while in service");
    // R3: nmi preempts
    nmi = 1; idle(3, "R3");
    chk("R3", 32'(vec), 32'h0024, "nmi vector");
    acc = 1; idle(2, "R3");
    chk("R3", 32'(take), 0, "nmi needs new edge");
    ret = 1; idle(1, "R9");
    ret = 1; idle(1, "R9");
    nmi = 0; lva = 0; lvb = 0;
    en_set = 1; idle(2, "R9");
    // R4: edge stored after short pulse, mask blocks, clear discards
    mask = 3'b001; edg = 1; idle(1, "R4"); edg = 0; idle(3, "R4");
    chk("R4", 32'(take), 0, "masked edge not presented");
    mask = 3'b000; idle(2, "R4");
    chk("R4", 32'(vec), 32'h003C, "held edge presented");
    eclr = 1; idle(2, "R4");
    chk("R4", 32'(take), 0, "edge cleared");
    // R8: general request ack
    gen = 1; idle(2, "R8");
    chk("R8", 32'(idx), 4, "general presented");
    acc = 1; idle(1, "R8");
    chk("R8", 32'(ack), 1, "ack pulse");
    idle(1, "R8");
    chk("R8", 32'(ack), 0, "ack single");
    gen = 0; ret = 1; idle(1, "R9");
    // R10: stray accept
    acc = 1; idle(2, "R10");
    chk("R10", 32'(take), 0, "stray accept ignored");
    // R3: nmi pulse that falls is withdrawn
    nmi = 1; idle(1, "R3"); nmi = 0; idle(3, "R3");
    chk("R3", 32'(take), 0, "short nmi withdrawn");

    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 16 == 0) nmi = ~nmi;
      if ($urandom % 6 == 0) edg = ~edg;
      if ($urandom % 5 == 0) lva = ~lva;
      if ($urandom % 5 == 0) lvb = ~lvb;
      if ($urandom % 5 == 0) gen = ~gen;
      if ($urandom % 20 == 0) mask = 3'($urandom);
      en_set = ($urandom % 4 == 0);
      en_clr = ($urandom % 32 == 0);
      eclr = ($urandom % 32 == 0);
      ret = ($urandom % 8 == 0);
      acc = take ? ($urandom % 2 == 0) : ($urandom % 16 == 0);
      step("R2");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule